// File: doc/BRIEF.md
# Dual-Port Word Memory with Independent Port Controls

This block is a clocked storage array of 4096 eight-bit words. Two ports, A and B, reach it. Each port has its own address, write data, read data, and three active-low controls: select, write strobe and output gate. The two ports are fully independent. In any single cycle, each port can read or write any location, whatever the other port is doing. The pad-level bidirectional bus is split into three signals per port: a write-data input, a read-data output and a drive flag. The drive flag says when a real pad would be driving. A standby flag per port reports when that port is deselected.

Each port has a mode register that is loaded every cycle from its three controls. The four modes are PM_STANDBY, PM_IDLE, PM_READ and PM_WRITE:

- Select high gives PM_STANDBY, whatever the other two controls are.
- Select low with the write strobe low gives PM_WRITE.
- Select low, write strobe high and output gate low gives PM_READ.
- Select low with both the write strobe and the output gate high gives PM_IDLE.

Every mode can move to every other mode on the next clock edge. The decoded mode is the only thing that chooses the transition. Reset places both ports in PM_STANDBY.

The block does not arbitrate between the ports. When both ports are selected on the same address and at least one of them writes, a collision pulse is raised one cycle later. If both ports write one word in the same cycle, the port A data is the value stored. A read on one port sees a same-cycle write from the other port: the new word appears with the usual one-cycle read latency.

Top module: `dpram_dual_port`

## Requirements
- R1: The array holds 2**12 words of 8 bits. The lowest address (0x000) and the highest address (0xFFF) both store and return data through either port.
- R2: If a port's select is high at a clock edge, then after that edge the port shows standby=1 and drive=0. No word is written, even if the write strobe is low.
- R3: If select and the write strobe are both low at an edge, the write data is stored at the address. After that edge, drive is 0 whatever the output gate is.
- R4: If select is low, the write strobe high and the output gate low at an edge, then after that edge drive is 1 and the read data equals the addressed word. The read latency is one cycle.
- R5: If select is low and both the write strobe and the output gate are high, then after that edge drive=0 and standby=0.
- R6: Whenever a port's drive is 0, its read data output is 0x00.
- R7: A word written on one port can be read on the other port. A same-cycle read of the written address on the other port returns the new word one cycle later.
- R8: One cycle after an edge, the collision output is 1 exactly when, at that edge, both selects were low, the addresses were equal, and at least one write strobe was low.
- R9: If both ports write the same address in the same cycle, the port A data is the value stored.
- R10: While reset is low, both ports show standby=1, drive=0 and read data 0x00, and collision is 0. Reset does not clear the stored words.
- R11: Two ports working on different addresses in the same cycle do not disturb each other's reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 8 | Port A write data |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_gate_n | input | 1 | Port A output gate, active low |
| a_rdata | output | 8 | Port A read data (0x00 when not driving) |
| a_drive | output | 1 | Port A output driver on |
| a_standby | output | 1 | Port A deselected |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 8 | Port B write data |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_gate_n | input | 1 | Port B output gate, active low |
| b_rdata | output | 8 | Port B read data (0x00 when not driving) |
| b_drive | output | 1 | Port B output driver on |
| b_standby | output | 1 | Port B deselected |
| collide | output | 1 | Same-address access with a write, one cycle late |

## Verification
The embedded properties check, on every cycle, how each port's controls map to its standby and drive flags one edge later. They also check that read data is zero while a port is not driving, that every collision pulse has a real cause, and that port A's data wins a double write. Only the bench's scenarios can show the returned data values: that the data crosses from one port to the other, that a write made in standby is really dropped, that stored words survive reset, and that both ends of the address range work.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'd0,
        PM_IDLE    = 2'd1,
        PM_READ    = 2'd2,
        PM_WRITE   = 2'd3
    } port_mode_e;

    // Select dominates; write strobe beats output gate.
    function automatic port_mode_e decode_mode(input logic sel_n,
                                               input logic wr_n,
                                               input logic gate_n);
        port_mode_e m;
        if (sel_n)       m = PM_STANDBY;
        else if (!wr_n)  m = PM_WRITE;
        else if (!gate_n) m = PM_READ;
        else             m = PM_IDLE;
        return m;
    endfunction

endpackage

// File: rtl/dpm_port_ctrl.sv
module dpm_port_ctrl
    import dpm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              gate_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              drive,
    output logic              standby
);

    port_mode_e          mode_d;
    port_mode_e          mode_q;
    logic [DATA_W-1:0]   rdata_q;

    always_comb begin
        mode_d = decode_mode(sel_n, wr_n, gate_n);
        wr_en  = (mode_d == PM_WRITE);
    end

    // State register: next mode comes only from this cycle's controls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= PM_STANDBY;
            rdata_q <= '0;
        end else begin
            mode_q  <= mode_d;
            rdata_q <= (mode_d == PM_READ) ? rd_word : '0;
        end
    end

    // Output process.
    always_comb begin
        drive   = 1'b0;
        standby = 1'b0;
        unique case (mode_q)
            PM_STANDBY: standby = 1'b1;
            PM_IDLE:    drive   = 1'b0;
            PM_READ:    drive   = 1'b1;
            PM_WRITE:   drive   = 1'b0;
            default:    standby = 1'b1;
        endcase
    end

    assign rdata = rdata_q;

    AST_DESELECT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (standby && !drive));                               // R2
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> (!drive && !standby));                  // R3
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !gate_n) |=> drive);                       // R4
    AST_GATE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && gate_n) |=> (!drive && !standby));         // R5
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (rdata == '0));                                    // R6

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              same_addr;
    logic              b_commit;

    assign same_addr = (a_addr == b_addr);
    // Port A wins a double write to one word.
    assign b_commit  = b_we && !(a_we && same_addr);

    always_ff @(posedge clk) begin
        if (a_we)     mem[a_addr] <= a_wdata;
        if (b_commit) mem[b_addr] <= b_wdata;
    end

    // Cross-port write-through: a reader sees the other port's same-cycle write.
    always_comb begin
        a_word = (b_we && same_addr) ? b_wdata : mem[a_addr];
        b_word = (a_we && same_addr) ? a_wdata : mem[b_addr];
    end

    AST_A_WINS_DOUBLE_WRITE: assert property (@(posedge clk)
        (a_we && b_we && same_addr) |=> (mem[$past(a_addr)] == $past(a_wdata))); // R9

endmodule

// File: rtl/dpm_collide.sv
module dpm_collide #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_wr_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_sel_n,
    input  logic              b_wr_n,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              collide
);

    logic hit;

    always_comb begin
        hit = !a_sel_n && !b_sel_n && (a_addr == b_addr) && (!a_wr_n || !b_wr_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) collide <= 1'b0;
        else        collide <= hit;
    end

    AST_COLLIDE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> ($past(!a_sel_n && !b_sel_n) && $past(!a_wr_n || !b_wr_n))); // R8
    AST_READS_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_n && b_wr_n) |=> !collide);                                        // R8

endmodule

// File: rtl/dpram_dual_port.sv
module dpram_dual_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_sel_n,
    input  logic              a_wr_n,
    input  logic              a_gate_n,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_drive,
    output logic              a_standby,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_sel_n,
    input  logic              b_wr_n,
    input  logic              b_gate_n,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_drive,
    output logic              b_standby,
    output logic              collide
);

    logic              a_we, b_we;
    logic [DATA_W-1:0] a_word, b_word;

    dpm_port_ctrl #(.DATA_W(DATA_W)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .sel_n(a_sel_n), .wr_n(a_wr_n), .gate_n(a_gate_n),
        .rd_word(a_word), .wr_en(a_we),
        .rdata(a_rdata), .drive(a_drive), .standby(a_standby)
    );

    dpm_port_ctrl #(.DATA_W(DATA_W)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .sel_n(b_sel_n), .wr_n(b_wr_n), .gate_n(b_gate_n),
        .rd_word(b_word), .wr_en(b_we),
        .rdata(b_rdata), .drive(b_drive), .standby(b_standby)
    );

    dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_word(a_word), .b_word(b_word)
    );

    dpm_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
        .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_addr(b_addr),
        .collide(collide)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (a_standby && b_standby && !a_drive && !b_drive && !collide)); // R10

endmodule

// File: tb/dpram_dual_port_bench.sv
module dpram_dual_port_bench;

    localparam int CLK_HALF = 10;   // 50 MHz

    // Control codes {sel_n, wr_n, gate_n}
    localparam logic [2:0] WR  = 3'b001;
    localparam logic [2:0] WRG = 3'b000;
    localparam logic [2:0] RD  = 3'b010;
    localparam logic [2:0] ID  = 3'b011;
    localparam logic [2:0] SB  = 3'b111;
    localparam logic [2:0] SBW = 3'b100;

    typedef struct packed {
        logic [2:0]  a_ctl; logic [11:0] a_adr; logic [7:0] a_wd;
        logic [2:0]  b_ctl; logic [11:0] b_adr; logic [7:0] b_wd;
        logic        a_sb;  logic a_dr; logic [7:0] a_rd;
        logic        b_sb;  logic b_dr; logic [7:0] b_rd;
        logic        col;   logic [23:0] tag;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{WR,  12'h000, 8'h5A, WR,  12'hFFF, 8'hC3, 1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b0, "R1 "}, // R3 R11
        '{RD,  12'hFFF, 8'h00, RD,  12'h000, 8'h00, 1'b0,1'b1,8'hC3, 1'b0,1'b1,8'h5A, 1'b0, "R7 "}, // R1 R4
        '{WR,  12'h123, 8'h77, RD,  12'h123, 8'h00, 1'b0,1'b0,8'h00, 1'b0,1'b1,8'h77, 1'b1, "R7 "}, // R8
        '{RD,  12'h456, 8'h00, WR,  12'h456, 8'h99, 1'b0,1'b1,8'h99, 1'b0,1'b0,8'h00, 1'b1, "R8 "}, // R7
        '{WR,  12'h200, 8'h11, WR,  12'h200, 8'h22, 1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1, "R8 "},
        '{RD,  12'h200, 8'h00, RD,  12'h200, 8'h00, 1'b0,1'b1,8'h11, 1'b0,1'b1,8'h11, 1'b0, "R9 "},
        '{SBW, 12'h123, 8'hEE, ID,  12'h123, 8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b0, "R2 "}, // R5 R6
        '{RD,  12'h123, 8'h00, SB,  12'h000, 8'h00, 1'b0,1'b1,8'h77, 1'b1,1'b0,8'h00, 1'b0, "R2 "},
        '{WRG, 12'h300, 8'hAB, SBW, 12'h300, 8'h44, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0, "R3 "},
        '{ID,  12'h000, 8'h00, RD,  12'h300, 8'h00, 1'b0,1'b0,8'h00, 1'b0,1'b1,8'hAB, 1'b0, "R5 "}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [7:0]  a_wdata = '0, b_wdata = '0;
    logic        a_sel_n = 1'b1, a_wr_n = 1'b1, a_gate_n = 1'b1;
    logic        b_sel_n = 1'b1, b_wr_n = 1'b1, b_gate_n = 1'b1;
    logic [7:0]  a_rdata, b_rdata;
    logic        a_drive, a_standby, b_drive, b_standby, collide;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    dpram_dual_port u_dpram_dual_port (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_sel_n(a_sel_n), .a_wr_n(a_wr_n),
        .a_gate_n(a_gate_n), .a_rdata(a_rdata), .a_drive(a_drive), .a_standby(a_standby),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_sel_n(b_sel_n), .b_wr_n(b_wr_n),
        .b_gate_n(b_gate_n), .b_rdata(b_rdata), .b_drive(b_drive), .b_standby(b_standby),
        .collide(collide)
    );

    task automatic chk(input string what, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_in(input logic [2:0] ac, input logic [11:0] aa, input logic [7:0] aw,
                            input logic [2:0] bc, input logic [11:0] ba, input logic [7:0] bw);
        {a_sel_n, a_wr_n, a_gate_n} = ac; a_addr = aa; a_wdata = aw;
        {b_sel_n, b_wr_n, b_gate_n} = bc; b_addr = ba; b_wdata = bw;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic asb, input logic adr, input logic [7:0] ard,
                           input logic bsb, input logic bdr, input logic [7:0] brd, input logic col);
        chk("a_standby", req, {7'd0, a_standby}, {7'd0, asb});
        chk("a_drive",   req, {7'd0, a_drive},   {7'd0, adr});
        chk("a_rdata",   req, a_rdata, ard);
        chk("b_standby", req, {7'd0, b_standby}, {7'd0, bsb});
        chk("b_drive",   req, {7'd0, b_drive},   {7'd0, bdr});
        chk("b_rdata",   req, b_rdata, brd);
        chk("collide",   req, {7'd0, collide},   {7'd0, col});
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        @(negedge clk);
        chk_all("R10", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        cycle();
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive_in(TBL[i].a_ctl, TBL[i].a_adr, TBL[i].a_wd,
                     TBL[i].b_ctl, TBL[i].b_adr, TBL[i].b_wd);
            cycle();
            chk_all(string'(TBL[i].tag), TBL[i].a_sb, TBL[i].a_dr, TBL[i].a_rd,
                    TBL[i].b_sb, TBL[i].b_dr, TBL[i].b_rd, TBL[i].col);
        end

        // R3: write with gate low on port B, no drive; then read back via A
        drive_in(ID, 12'h000, 8'h00, WRG, 12'h7FF, 8'h3C);
        cycle();
        chk("b_drive during write", "R3", {7'd0, b_drive}, 8'h00);
        drive_in(RD, 12'h7FF, 8'h00, ID, 12'h000, 8'h00);
        cycle();
        chk("a_rdata readback", "R3", a_rdata, 8'h3C);

        // R8: one port selected, other deselected, same address with write -> no pulse
        drive_in(WR, 12'h7FF, 8'h01, SB, 12'h7FF, 8'h00);
        cycle();
        chk("collide one side off", "R8", {7'd0, collide}, 8'h00);

        // R10: reset mid-run keeps memory
        rst_n = 1'b0;
        drive_in(RD, 12'h300, 8'h00, RD, 12'hFFF, 8'h00);
        #1;
        chk_all("R10", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        cycle();
        rst_n = 1'b1;
        cycle();
        chk("a_rdata kept", "R10", a_rdata, 8'hAB);
        chk("b_rdata kept", "R1",  b_rdata, 8'hC3);

        // R6: drop to idle, data returns to zero
        drive_in(ID, 12'h300, 8'h00, SB, 12'h000, 8'h00);
        cycle();
        chk("a_rdata idle", "R6", a_rdata, 8'h00);
        chk("b_rdata standby", "R6", b_rdata, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule